// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block sits on the device side of an asynchronous DRAM interface. A fast sampling clock samples the row strobe, the per-lane column strobes, the write enable and the output enable. From the order in which their edges arrive, the block names each row-strobe cycle as one of seven operations. There are three normal accesses: read, early write and read-modify-write. There are four refresh kinds: row-strobe-only, column-before-row, hidden and self-refresh.

The block keeps the internal refresh row pointer used by the refresh kinds that take no address. It also decides when the data pins should be driven. Driving follows the extended-data-out rule: data stays on the pins after the column strobe rises, and is withdrawn only once both strobes are high. A memory array model or a protocol monitor can take the operation report and the drive flag and act on them.

Each completed cycle is reported as one `op_valid` pulse carrying `op_type` and `op_row`. The report is a plain strobe with no ready input. There is no back-pressure, so the consumer must capture every pulse in the cycle it appears. Two reports are always at least two clocks apart, because a row-strobe cycle needs at least one low and one high sample.

Top module: `strobe_op_decoder`

## Requirements
- R1: If the row strobe falls while every column strobe is high, and no column strobe falls before the row strobe rises, the cycle is reported as row-only refresh (code 3). Its row is the address sampled in the clock where the row strobe fell, `dq_drive` stays 0, and `refresh_row` is unchanged.
- R2: If any column strobe is low when the row strobe falls and no read data is being held, the cycle is column-before-row refresh (code 4). Its row is the current `refresh_row`, and `dq_drive` stays 0 whatever the output enable and write enable are.
- R3: If the row strobe falls with a column strobe low while read data is being held, the cycle is a hidden refresh (code 5). Its row is the current `refresh_row`, and `dq_drive` keeps its value through the cycle.
- R4: `refresh_row` rises by one, modulo 2^ROW_BITS, in the clock that reports a code 4, 5 or 6 cycle. All other cycle types leave it unchanged.
- R5: In a cycle opened with all column strobes high, the first column strobe fall decides the access. If the write enable is high, the cycle is a read (code 0). If the write enable is already low, the cycle is an early write (code 1) and `dq_drive` stays 0.
- R6: A read cycle in which the write enable goes low while a column strobe is low, after the first column strobe fall, is reported as read-modify-write (code 2).
- R7: In a read, `dq_drive` goes to 1 one clock after the first column strobe fall, but only when the output enable is low. It stays 1 after the column strobes rise while the row strobe is still low. It drops one clock after both strobes are high, or after the write enable falls in that access.
- R8: A code 4 cycle whose row strobe stays low for more than SELF_CYCLES clocks is reported as self-refresh (code 6). If it stays low for exactly SELF_CYCLES clocks, it remains code 4.
- R9: `op_valid` is a single-clock pulse, in the clock after the row strobe is first sampled high. It carries `op_type` and `op_row`, and the row of a normal access is the address at the row strobe fall.
- R10: After reset, `op_valid`, `dq_drive` and `refresh_row` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | NCAS | Per-lane column strobes, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_BITS | Multiplexed address pins |
| op_valid | output | 1 | One-clock report of a finished row-strobe cycle |
| op_type | output | 3 | Operation code, 0 to 6 as listed in the requirements |
| op_row | output | ROW_BITS | Row touched by the reported cycle |
| refresh_row | output | ROW_BITS | Internal refresh row pointer |
| dq_drive | output | 1 | Data pins should be driven |

## Verification
An internal classification fault shows up in the very next report as a wrong `op_type`. That happens at most one clock after the row strobe rises, so every swept cycle pins down its own decision. A wrong refresh pointer shows up as a wrong `op_row` on the following refresh, and the bench also compares `refresh_row` after every cycle. A wrong hold state shows as `dq_drive` being off one clock after a read column fall, or still on one clock after both strobes rise. The bench samples `dq_drive` in exactly those clocks.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_EWRITE  = 3'd1,
    OP_RMW     = 3'd2,
    OP_RASONLY = 3'd3,
    OP_CBR     = 3'd4,
    OP_HIDDEN  = 3'd5,
    OP_SELF    = 3'd6
  } op_e;
endpackage

// File: rtl/strobe_edges.sv
// Samples the strobes once per clock and flags their edges.
module strobe_edges #(
  parameter int NCAS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ras_n,
  input  logic [NCAS-1:0] cas_n,
  output logic            ras_fall,
  output logic            ras_rise,
  output logic            cas_fall,
  output logic            cas_low
);
  logic ras_q;
  logic cas_low_q;

  assign cas_low  = |(~cas_n);
  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = ~cas_low_q & cas_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q     <= 1'b1;
      cas_low_q <= 1'b0;
    end else begin
      ras_q     <= ras_n;
      cas_low_q <= cas_low;
    end
  end
endmodule

// File: rtl/refresh_ctr.sv
// Internal refresh row pointer, wraps at the row count.
module refresh_ctr #(
  parameter int ROW_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                inc,
  output logic [ROW_BITS-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)   ptr <= '0;
    else if (inc) ptr <= ptr + 1'b1;
  end
endmodule

// File: rtl/dq_hold.sv
// Extended-data-out hold: read data stays valid until both strobes are high.
module dq_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  input  logic cas_low,
  input  logic oe_n,
  input  logic set_hold,
  input  logic wr_clear,
  output logic hold_q,
  output logic dq_drive
);
  logic hold_nxt;

  always_comb begin
    hold_nxt = hold_q;
    if (ras_n && !cas_low) hold_nxt = 1'b0;
    else if (wr_clear)     hold_nxt = 1'b0;
    else if (set_hold)     hold_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q   <= 1'b0;
      dq_drive <= 1'b0;
    end else begin
      hold_q   <= hold_nxt;
      dq_drive <= hold_nxt & ~oe_n;
    end
  end
endmodule

// File: rtl/cycle_sorter.sv
// Names each row-strobe cycle from the order of strobe and write-enable edges.
module cycle_sorter
  import strobe_dec_pkg::*;
#(
  parameter int ROW_BITS    = 12,
  parameter int SELF_CYCLES = 12500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                we_n,
  input  logic [ROW_BITS-1:0] addr,
  input  logic                ras_fall,
  input  logic                ras_rise,
  input  logic                cas_fall,
  input  logic                cas_low,
  input  logic                hold_q,
  input  logic [ROW_BITS-1:0] ref_row,
  output logic                op_valid,
  output op_e                 op_type,
  output logic [ROW_BITS-1:0] op_row,
  output logic                ref_inc,
  output logic                set_hold,
  output logic                wr_clear
);
  localparam int CNT_W = $clog2(SELF_CYCLES + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SELF_CYCLES);

  logic                in_cycle;
  logic                ras_low_in;
  op_e                 kind, kind_nxt, fin_type;
  logic [ROW_BITS-1:0] row_q;
  logic [CNT_W-1:0]    low_cnt;

  assign ras_low_in = in_cycle & ~ras_n;

  always_comb begin
    kind_nxt = kind;
    if (kind == OP_RASONLY && cas_fall)
      kind_nxt = we_n ? OP_READ : OP_EWRITE;
    else if (kind == OP_READ && cas_low && !we_n)
      kind_nxt = OP_RMW;
  end

  assign fin_type = (kind == OP_CBR && low_cnt == SAT) ? OP_SELF : kind;
  assign ref_inc  = in_cycle & ras_rise & (kind == OP_CBR || kind == OP_HIDDEN);
  assign set_hold = ras_low_in & cas_fall & we_n &
                    (kind == OP_RASONLY || kind == OP_READ);
  assign wr_clear = ras_low_in & ~we_n & (kind == OP_READ || kind == OP_RMW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_cycle <= 1'b0;
      kind     <= OP_RASONLY;
      row_q    <= '0;
      low_cnt  <= '0;
      op_valid <= 1'b0;
      op_type  <= OP_READ;
      op_row   <= '0;
    end else begin
      op_valid <= 1'b0;
      if (ras_fall) begin
        in_cycle <= 1'b1;
        low_cnt  <= '0;
        if (cas_low) begin
          kind  <= hold_q ? OP_HIDDEN : OP_CBR;
          row_q <= ref_row;
        end else begin
          kind  <= OP_RASONLY;
          row_q <= addr;
        end
      end else if (in_cycle && ras_rise) begin
        in_cycle <= 1'b0;
        op_valid <= 1'b1;
        op_type  <= fin_type;
        op_row   <= row_q;
      end else if (ras_low_in) begin
        if (low_cnt != SAT) low_cnt <= low_cnt + 1'b1;
        kind <= kind_nxt;
      end
    end
  end
endmodule

// File: rtl/strobe_op_decoder.sv
module strobe_op_decoder
  import strobe_dec_pkg::*;
#(
  parameter int ROW_BITS    = 12,
  parameter int NCAS        = 4,
  parameter int SELF_CYCLES = 12500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic [NCAS-1:0]     cas_n,
  input  logic                we_n,
  input  logic                oe_n,
  input  logic [ROW_BITS-1:0] addr,
  output logic                op_valid,
  output logic [2:0]          op_type,
  output logic [ROW_BITS-1:0] op_row,
  output logic [ROW_BITS-1:0] refresh_row,
  output logic                dq_drive
);
  logic ras_fall, ras_rise, cas_fall, cas_low;
  logic hold_q, set_hold, wr_clear, ref_inc;
  op_e  op_type_e;

  strobe_edges #(.NCAS(NCAS)) u_edges (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .ras_fall(ras_fall), .ras_rise(ras_rise),
    .cas_fall(cas_fall), .cas_low(cas_low)
  );

  cycle_sorter #(.ROW_BITS(ROW_BITS), .SELF_CYCLES(SELF_CYCLES)) u_sorter (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .we_n(we_n), .addr(addr),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .cas_fall(cas_fall),
    .cas_low(cas_low), .hold_q(hold_q), .ref_row(refresh_row),
    .op_valid(op_valid), .op_type(op_type_e), .op_row(op_row),
    .ref_inc(ref_inc), .set_hold(set_hold), .wr_clear(wr_clear)
  );

  refresh_ctr #(.ROW_BITS(ROW_BITS)) u_ref (
    .clk(clk), .rst_n(rst_n), .inc(ref_inc), .ptr(refresh_row)
  );

  dq_hold u_hold (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_low(cas_low), .oe_n(oe_n),
    .set_hold(set_hold), .wr_clear(wr_clear),
    .hold_q(hold_q), .dq_drive(dq_drive)
  );

  assign op_type = op_type_e;
endmodule

// File: rtl/strobe_op_decoder_chk.sv
module strobe_op_decoder_chk
  import strobe_dec_pkg::*;
#(
  parameter int ROW_BITS = 12,
  parameter int NCAS     = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ras_n,
  input logic [NCAS-1:0]     cas_n,
  input logic                oe_n,
  input logic                op_valid,
  input logic [2:0]          op_type,
  input logic [ROW_BITS-1:0] refresh_row,
  input logic                dq_drive
);
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R9

  AST_VALID_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> ($past(ras_n) && !$past(ras_n, 2))); // R9

  AST_REF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_row != $past(refresh_row)) |->
      (refresh_row == $past(refresh_row) + 1'b1 && op_valid &&
       (op_type == 3'(OP_CBR) || op_type == 3'(OP_HIDDEN) ||
        op_type == 3'(OP_SELF)))); // R4

  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ras_n && (&cas_n)) |-> !dq_drive); // R7

  AST_DRIVE_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_drive |-> !$past(oe_n)); // R7

  AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_type != 3'd7)); // R9
endmodule

bind strobe_op_decoder strobe_op_decoder_chk #(.ROW_BITS(ROW_BITS), .NCAS(NCAS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .oe_n(oe_n),
  .op_valid(op_valid), .op_type(op_type), .refresh_row(refresh_row),
  .dq_drive(dq_drive)
);

// File: tb/test_strobe_op_decoder.sv
module test_strobe_op_decoder;
  localparam int RB   = 3;
  localparam int NC   = 4;
  localparam int SELF = 8;
  localparam int ROWS = 1 << RB;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ras_n = 1'b1;
  logic [NC-1:0] cas_n = '1;
  logic          we_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [RB-1:0] addr = '0;
  logic          op_valid;
  logic [2:0]    op_type;
  logic [RB-1:0] op_row;
  logic [RB-1:0] refresh_row;
  logic          dq_drive;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int ref_exp = 0;
  bit done = 0;

  strobe_op_decoder #(.ROW_BITS(RB), .NCAS(NC), .SELF_CYCLES(SELF)) i_strobe_op_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .addr(addr), .op_valid(op_valid), .op_type(op_type),
    .op_row(op_row), .refresh_row(refresh_row), .dq_drive(dq_drive)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  // Reports arrive one clock after the row strobe rises.
  task automatic expect_op(input string req, input int typ, input int row);
    chk({req, " R9 valid"}, int'(op_valid), 1);
    chk({req, " type"}, int'(op_type), typ);
    chk({req, " row"}, int'(op_row), row);
    chk({req, " R4 refresh_row"}, int'(refresh_row), ref_exp);
    step();
    chk("R9 single pulse", int'(op_valid), 0);
  endtask

  // mode: 0 read, 1 early write, 2 read-modify-write
  task automatic normal_cycle(input int row, input int mode, input bit oe);
    int exp_type;
    oe_n = oe;
    addr = RB'(row);
    ras_n = 1'b0;
    step();
    addr = ~RB'(row);
    we_n = (mode == 1) ? 1'b0 : 1'b1;
    cas_n = ~(NC'(1) << (row % NC));
    step();
    chk((mode == 1) ? "R5 early write no drive" : "R7 drive after cas fall",
        int'(dq_drive), (mode != 1 && !oe) ? 1 : 0);
    if (mode == 2) begin
      we_n = 1'b0;
      step();
      chk("R7 drive off on write", int'(dq_drive), 0);
    end
    cas_n = '1;
    step();
    chk("R7 edo hold", int'(dq_drive), (mode == 0 && !oe) ? 1 : 0);
    ras_n = 1'b1;
    we_n = 1'b1;
    step();
    chk("R7 off after both high", int'(dq_drive), 0);
    exp_type = (mode == 0) ? 0 : (mode == 1) ? 1 : 2;
    expect_op((mode == 2) ? "R6" : "R5", exp_type, row);
  endtask

  task automatic ras_only(input int row);
    oe_n = 1'b0;
    addr = RB'(row);
    ras_n = 1'b0;
    step();
    addr = ~RB'(row);
    step(2);
    chk("R1 no drive", int'(dq_drive), 0);
    ras_n = 1'b1;
    step();
    expect_op("R1", 3, row);
  endtask

  task automatic cbr(input int len, input int lane);
    int r;
    oe_n = 1'b0;
    we_n = 1'b0;
    cas_n = ~(NC'(1) << lane);
    step();
    ras_n = 1'b0;
    step(len);
    chk("R2 no drive oe/we low", int'(dq_drive), 0);
    ras_n = 1'b1;
    step();
    r = ref_exp;
    ref_exp = (ref_exp + 1) % ROWS;
    expect_op((len > SELF) ? "R8 self" : "R8 cbr", (len > SELF) ? 6 : 4, r);
    cas_n = '1;
    we_n = 1'b1;
    step();
  endtask

  task automatic hidden(input int row);
    int r;
    oe_n = 1'b0;
    addr = RB'(row);
    ras_n = 1'b0;
    step();
    cas_n = '0;
    step();
    chk("R7 read drive", int'(dq_drive), 1);
    ras_n = 1'b1;
    step();
    expect_op("R3 lead read", 0, row);
    chk("R3 drive kept in precharge", int'(dq_drive), 1);
    ras_n = 1'b0;
    step(3);
    chk("R3 drive kept in refresh", int'(dq_drive), 1);
    ras_n = 1'b1;
    step();
    r = ref_exp;
    ref_exp = (ref_exp + 1) % ROWS;
    expect_op("R3", 5, r);
    chk("R3 drive after refresh", int'(dq_drive), 1);
    cas_n = '1;
    step(2);
    chk("R7 drive off at last rise", int'(dq_drive), 0);
  endtask

  initial begin
    step(4);
    chk("R10 op_valid", int'(op_valid), 0);
    chk("R10 dq_drive", int'(dq_drive), 0);
    chk("R10 refresh_row", int'(refresh_row), 0);
    rst_n = 1'b1;
    step(2);
    for (int row = 0; row < ROWS; row++) ras_only(row);
    for (int row = 0; row < ROWS; row++)
      for (int mode = 0; mode < 3; mode++)
        for (int oe = 0; oe < 2; oe++) normal_cycle(row, mode, oe[0]);
    for (int len = 2; len <= SELF + 3; len++) cbr(len, len % NC);
    for (int k = 0; k < 3; k++) hidden(k + 2);
    ras_only(5);
    chk("R4 wrap total", int'(refresh_row), ref_exp);
    done = 1;
    finish_run();
  end
endmodule